// File: doc/BRIEF.md
# Coherent Wide Register Access over a Byte Bus

This block sits between an 8-bit register bus and one peripheral value that is 2, 3 or 4 bytes wide. Software cannot move all bytes of such a value in one bus access, so the block keeps hidden holding bytes. Writes to every byte except the top one are parked in the holding bytes. The write to the top byte then commits the whole value in a single clock cycle. Reads start at byte 0. That read returns the live byte 0 and, in the same edge, freezes all the upper live bytes into the holding bytes. The later reads of the upper bytes come from that frozen copy. Software therefore sees a value that is consistent in time, even when the peripheral logic changes it between the accesses.

The peripheral side is a plain parallel port. `hw_we` loads `hw_value` into the live register on any cycle. The register always drives its current contents out on `live_value`. The holding bytes also appear in the address map, so software can read and write them directly. The width in bytes is the parameter `NBYTES` (2 to 4, default 4). With N = `NBYTES`, the address map is:

- Offsets 0 to N-1 are the register bytes, least significant first.
- Offsets N to 2N-2 are holding bytes 0 to N-2.
- All higher offsets are unmapped.

Top module: `atomic_reg_access`

## Requirements
- R1: After reset, `live_value` is zero and every holding byte reads zero.
- R2: A bus write to register byte k, with k < N-1, stores the data in holding byte k and leaves `live_value` unchanged.
- R3: A bus write to register byte N-1 sets `live_value` to {write data, holding byte N-2, ..., holding byte 0}. The new value is visible after that one clock edge.
- R4: A bus read of register byte 0 returns live bits [7:0] combinationally. At the same edge, holding byte j is loaded with live byte j+1.
- R5: A bus read of register byte k, with k ≥ 1, returns holding byte k-1. This holds even when `hw_we` has changed the live value since the byte 0 read.
- R6: When a committing top-byte write and `hw_we` occur in the same cycle, the bus value is the one stored.
- R7: When `hw_we` is high and no commit occurs, `live_value` takes `hw_value` at the next edge.
- R8: Offset N+j reads and writes holding byte j directly. A value written there is used by the next commit.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes neither the live value nor any holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | $clog2(2*NBYTES) | Byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| hw_we | input | 1 | Peripheral load strobe |
| hw_value | input | 8*NBYTES | Peripheral load value |
| live_value | output | 8*NBYTES | Current register value |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high in the same cycle, because a bus performs one access per cycle. A dedicated check flags any violation of this. The random stimulus picks either a read, a write or an idle cycle for each operation, so the strobes are never both set. `hw_we` is driven freely, so it also lands in the same cycle as commits and between the bytes of a read sequence.

// File: rtl/atomic_reg_access.sv
module atomic_reg_access #(
  parameter int NBYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(2*NBYTES)-1:0]   bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic                          hw_we,
  input  logic [8*NBYTES-1:0]           hw_value,
  output logic [8*NBYTES-1:0]           live_value
);
  localparam int W  = 8 * NBYTES;
  localparam int NT = NBYTES - 1;
  localparam int AW = $clog2(2 * NBYTES);

  logic [W-1:0]    live_q;
  logic [8*NT-1:0] tmp_q;
  logic [AW-1:0]   toff;

  assign toff = bus_addr - AW'(NBYTES);

  wire in_reg  = bus_addr < AW'(NBYTES);
  wire in_tmp  = !in_reg && (bus_addr < AW'(2 * NBYTES - 1));
  wire commit  = bus_wr && (bus_addr == AW'(NT));
  wire snap    = bus_rd && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      tmp_q  <= '0;
    end else begin
      if (snap)
        tmp_q <= live_q[W-1:8];
      if (bus_wr && bus_addr < AW'(NT))
        tmp_q[int'(bus_addr)*8 +: 8] <= bus_wdata;
      if (bus_wr && in_tmp)
        tmp_q[int'(toff)*8 +: 8] <= bus_wdata;
      if (commit)
        live_q <= {bus_wdata, tmp_q};
      else if (hw_we)
        live_q <= hw_value;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0)
      bus_rdata = live_q[7:0];
    else if (in_reg)
      bus_rdata = tmp_q[(int'(bus_addr) - 1)*8 +: 8];
    else if (in_tmp)
      bus_rdata = tmp_q[int'(toff)*8 +: 8];
  end

  assign live_value = live_q;
endmodule

// File: rtl/atomic_reg_access_chk.sv
module atomic_reg_access_chk #(
  parameter int NBYTES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [$clog2(2*NBYTES)-1:0] bus_addr,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [7:0]                  bus_wdata,
  input logic [7:0]                  bus_rdata,
  input logic                        hw_we,
  input logic [8*NBYTES-1:0]         hw_value,
  input logic [8*NBYTES-1:0]         live_value,
  input logic [8*NBYTES-9:0]         tmp_q
);
  localparam int W  = 8 * NBYTES;
  localparam int AW = $clog2(2 * NBYTES);

  a_in_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R2
  a_r2_partial_write_holds_live: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr < AW'(NBYTES - 1) && !hw_we |=> $stable(live_value));

  // R3 and R6
  a_r3_commit_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(NBYTES - 1) |=> live_value[W-1:W-8] == $past(bus_wdata));

  a_r6_bus_beats_hw: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(NBYTES - 1) && hw_we |=>
      live_value[W-9:0] == $past(tmp_q));

  // R4
  a_r4_low_read_live: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == '0 |-> bus_rdata == live_value[7:0]);

  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == '0 |=> tmp_q == $past(live_value[W-1:8]));

  // R7
  a_r7_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we && !(bus_wr && bus_addr == AW'(NBYTES - 1)) |=> live_value == $past(hw_value));

  // R9
  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr > AW'(2 * NBYTES - 2) |-> bus_rdata == 8'h00);
endmodule

bind atomic_reg_access atomic_reg_access_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .hw_we(hw_we), .hw_value(hw_value), .live_value(live_value), .tmp_q(tmp_q)
);

// File: tb/tb_atomic_reg_access.sv
module tb_atomic_reg_access;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 8 * N;
  localparam int AW = $clog2(2 * N);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 0, bus_rd = 0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          hw_we = 0;
  logic [W-1:0]  hw_value = '0;
  logic [W-1:0]  live_value;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] m_live;
  logic [7:0]   m_tmp [N-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_reg_access #(.NBYTES(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_we(hw_we), .hw_value(hw_value), .live_value(live_value));

  function automatic logic [7:0] exp_read(input int a);
    if (a == 0) return m_live[7:0];
    if (a < N) return m_tmp[a-1];
    if (a < 2*N-1) return m_tmp[a-N];
    return 8'h00;
  endfunction

  function automatic string req_of_addr(input int a);
    if (a == 0) return "R4";
    if (a < N) return "R5";
    if (a < 2*N-1) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic op(input bit rd, input bit wr, input int a, input logic [7:0] d,
                    input bit hwe, input logic [W-1:0] hwd);
    string lreq;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    hw_we = hwe; hw_value = hwd;
    #1;
    if (rd) check(req_of_addr(a), W'(bus_rdata), W'(exp_read(a)));
    @(posedge clk);
    if (rd && a == 0)
      for (int j = 0; j < N-1; j++) m_tmp[j] = m_live[8*(j+1) +: 8];
    if (wr && a < N-1) m_tmp[a] = d;
    if (wr && a >= N && a < 2*N-1) m_tmp[a-N] = d;
    lreq = hwe ? "R7" : (wr && a >= 2*N-1) ? "R9" : "R2";
    if (wr && a == N-1) begin
      for (int j = 0; j < N-1; j++) m_live[8*j +: 8] = m_tmp[j];
      m_live[W-1 -: 8] = d;
      lreq = hwe ? "R6" : "R3";
    end else if (hwe) m_live = hwd;
    #1;
    check(lreq, live_value, m_live);
    bus_rd = 0; bus_wr = 0; hw_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_live = '0;
    for (int j = 0; j < N-1; j++) m_tmp[j] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check("R1", live_value, '0);
    for (int a = N; a < 2*N-1; a++) op(1, 0, a, 0, 0, '0);
    // R2 then R3: stage three bytes, commit with top
    op(0, 1, 0, 8'h11, 0, '0);
    op(0, 1, 1, 8'h22, 0, '0);
    op(0, 1, 2, 8'h33, 0, '0);
    op(0, 1, 3, 8'h44, 0, '0);
    check("R3", live_value, 32'h44332211);
    // R7 hardware load
    op(0, 0, 0, 0, 1, 32'hA5B6C7D8);
    // R4/R5: snapshot survives a hardware change
    op(1, 0, 0, 0, 0, '0);
    op(0, 0, 0, 0, 1, 32'h01020304);
    op(1, 0, 1, 0, 0, '0);
    op(1, 0, 2, 0, 1, 32'hFFFFFFFF);
    op(1, 0, 3, 0, 0, '0);
    // R6: commit collides with hardware load
    op(0, 1, 0, 8'hE1, 0, '0);
    op(0, 1, 3, 8'hE4, 1, 32'h12345678);
    // R8: direct holding access feeds commit
    op(0, 1, 4, 8'h5A, 0, '0);
    op(0, 1, 6, 8'hC3, 0, '0);
    op(1, 0, 4, 0, 0, '0);
    op(1, 0, 6, 0, 0, '0);
    op(0, 1, 3, 8'h7E, 0, '0);
    // R9: unmapped offset
    op(0, 1, 7, 8'hFF, 0, '0);
    op(1, 0, 7, 0, 0, '0);
    for (int a = N; a < 2*N-1; a++) op(1, 0, a, 0, 0, '0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int kind = $urandom_range(0, 2);
      op(kind == 1, kind == 2, $urandom_range(0, 2*N-1), 8'($urandom),
         ($urandom_range(0, 9) < 3), W'($urandom));
    end
    summary();
  end
endmodule